// File: doc/BRIEF.md
# Selectable Capture Trigger Generator

This block decides when a sample-capture engine should start storing data. A 5-bit selector picks one of 32 trigger conditions. The conditions draw on the receive path (frame check result, header check result, HT flag, preamble detection), on the radio front end (received signal strength, gain-control lock and gain value), and on the transmit path (start and done strobes, the baseband-active and RF-active levels, and a flag that marks a frame needing an acknowledgement). A further condition measures the I/Q amplitude of the second antenna while the first one transmits.

The block holds the edge detectors and the strict threshold comparators that these conditions need. It drives a registered trigger output that goes high on the clock edge that samples the qualifying inputs. Level crossings are reported only when a comparison result changes, so a signal that stays above or below a limit raises at most one pulse. The capture memory and the register programming that set the selector and the limits are outside this block.

Top module: `capture_trigger_gen`

## Requirements
- R1: Selector 0 fires on any frame-check strobe (`fcs_valid`). Selector 1 fires only when `fcs_ok`=1 with the strobe. Selector 2 fires only when `fcs_ok`=0 with the strobe.
- R2: Selector 3 fires on any header-check strobe (`sig_valid`). Selector 4 requires `sig_ok`=1 and selector 5 requires `sig_ok`=0. Selector 6 requires `sig_ht`=1 and selector 7 requires `sig_ht`=0, each with the strobe.
- R3: Selector 8 fires on `long_pre` and selector 9 fires on `short_pre`.
- R4: Selector 10 fires on the sample where `rssi > level_thresh` becomes true. Selector 11 fires on the sample where `rssi < level_thresh` becomes true. The comparisons are strict, and a level held on one side gives no repeated pulse.
- R5: Selector 12 fires when `agc_lock` goes from 1 to 0. Selector 13 fires when it goes from 0 to 1.
- R6: Selector 14 fires when `agc_gain > gain_thresh` becomes true. Selector 15 fires when `agc_gain < gain_thresh` becomes true. Both comparisons are strict.
- R7: Selector 16 fires on `tx_start` and selector 17 on `tx_done`. Selectors 18 and 19 fire on the rising and falling edges of `tx_bb_on`. Selectors 20 and 21 fire on the rising and falling edges of `tx_rf_on`.
- R8: Selectors 22 to 27 are the conditions of selectors 16 to 21, in the same order, gated by `tx_need_ack`=1 in the same sample.
- R9: Let the amplitude be |alt_i|+|alt_q|, with both inputs signed two's complement. It counts as high when strictly greater than `level_thresh`. Selector 28 fires each sample in which `tx_bb_on`=1 and the amplitude is high. Selector 29 does the same with `tx_rf_on`. Selector 30 fires on `tx_start` with a high amplitude, and selector 31 additionally requires `tx_need_ack`.
- R10: `trig` is registered. It rises on the clock edge that samples the qualifying inputs and reflects only the inputs of that one sample. The first sample after reset produces no edge or crossing event, whatever the level values are.
- R11: While `rst` is high, `trig` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 5 | Trigger condition selector |
| level_thresh | input | 11 | Limit for signal strength and for antenna amplitude |
| gain_thresh | input | 7 | Limit for gain-control gain |
| fcs_valid | input | 1 | Frame check result strobe |
| fcs_ok | input | 1 | Frame check passed |
| sig_valid | input | 1 | Header check result strobe |
| sig_ok | input | 1 | Header check passed |
| sig_ht | input | 1 | Frame is HT |
| long_pre | input | 1 | Long preamble detected strobe |
| short_pre | input | 1 | Short preamble detected strobe |
| rssi | input | 11 | Received strength, half-dB steps |
| agc_gain | input | 7 | Gain-control gain value |
| agc_lock | input | 1 | Gain-control lock level |
| tx_start | input | 1 | Transmit started strobe |
| tx_done | input | 1 | Transmit done strobe |
| tx_bb_on | input | 1 | Baseband transmit active level |
| tx_rf_on | input | 1 | RF transmit active level |
| tx_need_ack | input | 1 | Current transmit frame needs acknowledgement |
| alt_i | input | 16 | Second antenna I sample, signed |
| alt_q | input | 16 | Second antenna Q sample, signed |
| trig | output | 1 | Trigger pulse |

## Verification
Every result of this block is due exactly one clock edge after its inputs are applied. Inputs are driven on the falling edge, the rising edge samples them, and the bench compares `trig` on the next falling edge against a value it worked out from those same inputs before that rising edge. Edge and crossing results also depend on the previous sample. The bench therefore keeps its own copy of the prior levels and comparison outcomes, and it keeps a flag that suppresses events on the first sample after reset, so the one-edge window holds for the sampled-level conditions too.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_FCS_ANY     = 5'd0,  SEL_FCS_PASS    = 5'd1,  SEL_FCS_FAIL    = 5'd2,
    SEL_HDR_ANY     = 5'd3,  SEL_HDR_PASS    = 5'd4,  SEL_HDR_FAIL    = 5'd5,
    SEL_HDR_HT      = 5'd6,  SEL_HDR_LEGACY  = 5'd7,  SEL_PRE_LONG    = 5'd8,
    SEL_PRE_SHORT   = 5'd9,  SEL_RSSI_UP     = 5'd10, SEL_RSSI_DOWN   = 5'd11,
    SEL_LOCK_LOST   = 5'd12, SEL_LOCK_GAINED = 5'd13, SEL_GAIN_UP     = 5'd14,
    SEL_GAIN_DOWN   = 5'd15, SEL_TX_START    = 5'd16, SEL_TX_DONE     = 5'd17,
    SEL_BB_RISE     = 5'd18, SEL_BB_FALL     = 5'd19, SEL_RF_RISE     = 5'd20,
    SEL_RF_FALL     = 5'd21, SEL_ACK_START   = 5'd22, SEL_ACK_DONE    = 5'd23,
    SEL_ACK_BB_RISE = 5'd24, SEL_ACK_BB_FALL = 5'd25, SEL_ACK_RF_RISE = 5'd26,
    SEL_ACK_RF_FALL = 5'd27, SEL_BB_AMP      = 5'd28, SEL_RF_AMP      = 5'd29,
    SEL_START_AMP   = 5'd30, SEL_START_AMP_ACK = 5'd31
  } trig_sel_e;

  // lane positions inside the level edge detector
  localparam int LANE_LOCK = 0;
  localparam int LANE_BB   = 1;
  localparam int LANE_RF   = 2;
  localparam int N_LANES   = 3;
endpackage

// File: rtl/trig_level_edge.sv
module trig_level_edge #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  logic [LANES-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl;
      primed_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rise[k] = primed_q &  lvl[k] & ~prev_q[k];
    assign fall[k] = primed_q & ~lvl[k] &  prev_q[k];
  end

  // R10
  edge_prev_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise & $past(lvl)) == '0) && ((fall & ~$past(lvl)) == '0));
endmodule

// File: rtl/trig_level_cross.sv
module trig_level_cross #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] value,
  input  logic [W-1:0] limit,
  output logic         up_x,
  output logic         down_x
);
  logic above, below;
  logic above_q, below_q, primed_q;

  assign above = value > limit;
  assign below = value < limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q  <= 1'b0;
      below_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      above_q  <= above;
      below_q  <= below;
      primed_q <= 1'b1;
    end
  end

  assign up_x   = primed_q & above & ~above_q;
  assign down_x = primed_q & below & ~below_q;

  // R4
  no_repeat_up_chk: assert property (@(posedge clk) disable iff (rst)
    up_x |=> !up_x);
  // R6
  no_repeat_down_chk: assert property (@(posedge clk) disable iff (rst)
    down_x |=> !down_x);
endmodule

// File: rtl/trig_amp_gate.sv
module trig_amp_gate #(
  parameter int IQ_W = 16,
  parameter int TH_W = 11
) (
  input  logic signed [IQ_W-1:0] i_smp,
  input  logic signed [IQ_W-1:0] q_smp,
  input  logic        [TH_W-1:0] limit,
  output logic                   over
);
  localparam int SUM_W = IQ_W + 1;

  logic [IQ_W-1:0]  mag_i, mag_q;
  logic [SUM_W-1:0] amp;

  assign mag_i = i_smp[IQ_W-1] ? IQ_W'(-i_smp) : IQ_W'(i_smp);
  assign mag_q = q_smp[IQ_W-1] ? IQ_W'(-q_smp) : IQ_W'(q_smp);
  assign amp   = SUM_W'(mag_i) + SUM_W'(mag_q);
  assign over  = amp > SUM_W'(limit);
endmodule

// File: rtl/capture_trigger_gen.sv
module capture_trigger_gen
  import trig_sel_pkg::*;
#(
  parameter int RSSI_W = 11,
  parameter int GAIN_W = 7,
  parameter int IQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [RSSI_W-1:0] level_thresh,
  input  logic [GAIN_W-1:0] gain_thresh,
  input  logic              fcs_valid,
  input  logic              fcs_ok,
  input  logic              sig_valid,
  input  logic              sig_ok,
  input  logic              sig_ht,
  input  logic              long_pre,
  input  logic              short_pre,
  input  logic [RSSI_W-1:0] rssi,
  input  logic [GAIN_W-1:0] agc_gain,
  input  logic              agc_lock,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              tx_bb_on,
  input  logic              tx_rf_on,
  input  logic              tx_need_ack,
  input  logic [IQ_W-1:0]   alt_i,
  input  logic [IQ_W-1:0]   alt_q,
  output logic              trig
);
  logic [N_LANES-1:0] lvl, rise, fall;
  logic rssi_up, rssi_dn, gain_up, gain_dn, amp_hi;
  logic tx_ev [6];
  logic hit, trig_q;

  assign lvl[LANE_LOCK] = agc_lock;
  assign lvl[LANE_BB]   = tx_bb_on;
  assign lvl[LANE_RF]   = tx_rf_on;

  trig_level_edge #(.LANES(N_LANES)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall)
  );

  trig_level_cross #(.W(RSSI_W)) u_rssi_x (
    .clk(clk), .rst(rst), .value(rssi), .limit(level_thresh),
    .up_x(rssi_up), .down_x(rssi_dn)
  );

  trig_level_cross #(.W(GAIN_W)) u_gain_x (
    .clk(clk), .rst(rst), .value(agc_gain), .limit(gain_thresh),
    .up_x(gain_up), .down_x(gain_dn)
  );

  trig_amp_gate #(.IQ_W(IQ_W), .TH_W(RSSI_W)) u_amp (
    .i_smp(alt_i), .q_smp(alt_q), .limit(level_thresh), .over(amp_hi)
  );

  // transmit events shared by the plain and acknowledgement-gated groups
  assign tx_ev[0] = tx_start;
  assign tx_ev[1] = tx_done;
  assign tx_ev[2] = rise[LANE_BB];
  assign tx_ev[3] = fall[LANE_BB];
  assign tx_ev[4] = rise[LANE_RF];
  assign tx_ev[5] = fall[LANE_RF];

  always_comb begin
    hit = 1'b0;
    case (trig_sel_e'(cond_sel))
      SEL_FCS_ANY:       hit = fcs_valid;
      SEL_FCS_PASS:      hit = fcs_valid & fcs_ok;
      SEL_FCS_FAIL:      hit = fcs_valid & ~fcs_ok;
      SEL_HDR_ANY:       hit = sig_valid;
      SEL_HDR_PASS:      hit = sig_valid & sig_ok;
      SEL_HDR_FAIL:      hit = sig_valid & ~sig_ok;
      SEL_HDR_HT:        hit = sig_valid & sig_ht;
      SEL_HDR_LEGACY:    hit = sig_valid & ~sig_ht;
      SEL_PRE_LONG:      hit = long_pre;
      SEL_PRE_SHORT:     hit = short_pre;
      SEL_RSSI_UP:       hit = rssi_up;
      SEL_RSSI_DOWN:     hit = rssi_dn;
      SEL_LOCK_LOST:     hit = fall[LANE_LOCK];
      SEL_LOCK_GAINED:   hit = rise[LANE_LOCK];
      SEL_GAIN_UP:       hit = gain_up;
      SEL_GAIN_DOWN:     hit = gain_dn;
      SEL_TX_START:      hit = tx_ev[0];
      SEL_TX_DONE:       hit = tx_ev[1];
      SEL_BB_RISE:       hit = tx_ev[2];
      SEL_BB_FALL:       hit = tx_ev[3];
      SEL_RF_RISE:       hit = tx_ev[4];
      SEL_RF_FALL:       hit = tx_ev[5];
      SEL_ACK_START:     hit = tx_ev[0] & tx_need_ack;
      SEL_ACK_DONE:      hit = tx_ev[1] & tx_need_ack;
      SEL_ACK_BB_RISE:   hit = tx_ev[2] & tx_need_ack;
      SEL_ACK_BB_FALL:   hit = tx_ev[3] & tx_need_ack;
      SEL_ACK_RF_RISE:   hit = tx_ev[4] & tx_need_ack;
      SEL_ACK_RF_FALL:   hit = tx_ev[5] & tx_need_ack;
      SEL_BB_AMP:        hit = tx_bb_on & amp_hi;
      SEL_RF_AMP:        hit = tx_rf_on & amp_hi;
      SEL_START_AMP:     hit = tx_start & amp_hi;
      SEL_START_AMP_ACK: hit = tx_start & amp_hi & tx_need_ack;
      default:           hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= hit;
  end

  assign trig = trig_q;

  // R1
  fcs_pass_only_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 5'd1 && !(fcs_valid && fcs_ok)) |=> !trig);
  // R3
  long_pre_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 5'd8 && long_pre) |=> trig);
  // R8
  ack_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel >= 5'd22 && cond_sel <= 5'd27 && !tx_need_ack) |=> !trig);
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !trig);
endmodule

// File: tb/capture_trigger_gen_tb_top.sv
`timescale 1ns/1ps
module capture_trigger_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cond_sel = '0;
  logic [10:0] level_thresh = '0;
  logic [6:0]  gain_thresh = '0;
  logic fcs_valid = 0, fcs_ok = 0, sig_valid = 0, sig_ok = 0, sig_ht = 0;
  logic long_pre = 0, short_pre = 0;
  logic [10:0] rssi = '0;
  logic [6:0]  agc_gain = '0;
  logic agc_lock = 0, tx_start = 0, tx_done = 0, tx_bb_on = 0, tx_rf_on = 0;
  logic tx_need_ack = 0;
  logic [15:0] alt_i = '0, alt_q = '0;
  logic trig;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model state
  bit m_primed = 0;
  bit p_lock = 0, p_bb = 0, p_rf = 0, p_ra = 0, p_rb = 0, p_ga = 0, p_gb = 0;
  string tag_over = "";

  always #4 clk = ~clk;

  capture_trigger_gen dut_i (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .level_thresh(level_thresh),
    .gain_thresh(gain_thresh), .fcs_valid(fcs_valid), .fcs_ok(fcs_ok),
    .sig_valid(sig_valid), .sig_ok(sig_ok), .sig_ht(sig_ht),
    .long_pre(long_pre), .short_pre(short_pre), .rssi(rssi),
    .agc_gain(agc_gain), .agc_lock(agc_lock), .tx_start(tx_start),
    .tx_done(tx_done), .tx_bb_on(tx_bb_on), .tx_rf_on(tx_rf_on),
    .tx_need_ack(tx_need_ack), .alt_i(alt_i), .alt_q(alt_q), .trig(trig)
  );

  function automatic string req_of(int c);
    if (c <= 2)  return "R1";
    if (c <= 7)  return "R2";
    if (c <= 9)  return "R3";
    if (c <= 11) return "R4";
    if (c <= 13) return "R5";
    if (c <= 15) return "R6";
    if (c <= 21) return "R7";
    if (c <= 27) return "R8";
    return "R9";
  endfunction

  function automatic int mag(logic [15:0] v);
    int s = int'($signed(v));
    return (s < 0) ? -s : s;
  endfunction

  function automatic bit edge_up(bit primed, bit cur, bit prev);
    return primed && cur && !prev;
  endfunction

  task automatic report(string tag, bit act, bit exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: code=%0d trig=%0b expected %0b", tag, cond_sel, act, exp_v);
    end
  endtask

  // Computes the expected output for the inputs now applied, then waits one
  // clock (rising edge samples, falling edge compares).
  task automatic tick();
    bit ra, rb, ga, gb, amp_hi, e;
    bit ev [6];
    string tag;
    ra = rssi > level_thresh;       rb = rssi < level_thresh;
    ga = agc_gain > gain_thresh;    gb = agc_gain < gain_thresh;
    amp_hi = (mag(alt_i) + mag(alt_q)) > int'(level_thresh);
    ev[0] = tx_start; ev[1] = tx_done;
    ev[2] = edge_up(m_primed, tx_bb_on, p_bb);
    ev[3] = edge_up(m_primed, !tx_bb_on, !p_bb);
    ev[4] = edge_up(m_primed, tx_rf_on, p_rf);
    ev[5] = edge_up(m_primed, !tx_rf_on, !p_rf);
    case (int'(cond_sel))
      0:  e = fcs_valid;
      1:  e = fcs_valid && fcs_ok;
      2:  e = fcs_valid && !fcs_ok;
      3:  e = sig_valid;
      4:  e = sig_valid && sig_ok;
      5:  e = sig_valid && !sig_ok;
      6:  e = sig_valid && sig_ht;
      7:  e = sig_valid && !sig_ht;
      8:  e = long_pre;
      9:  e = short_pre;
      10: e = edge_up(m_primed, ra, p_ra);
      11: e = edge_up(m_primed, rb, p_rb);
      12: e = edge_up(m_primed, !agc_lock, !p_lock);
      13: e = edge_up(m_primed, agc_lock, p_lock);
      14: e = edge_up(m_primed, ga, p_ga);
      15: e = edge_up(m_primed, gb, p_gb);
      28: e = tx_bb_on && amp_hi;
      29: e = tx_rf_on && amp_hi;
      30: e = tx_start && amp_hi;
      31: e = tx_start && amp_hi && tx_need_ack;
      default: begin
        if (cond_sel <= 5'd21) e = ev[cond_sel - 5'd16];
        else                   e = ev[cond_sel - 5'd22] && tx_need_ack;
      end
    endcase
    tag = (tag_over != "") ? tag_over : req_of(int'(cond_sel));
    p_ra = ra; p_rb = rb; p_ga = ga; p_gb = gb;
    p_lock = agc_lock; p_bb = tx_bb_on; p_rf = tx_rf_on;
    m_primed = 1;
    @(negedge clk);
    report(tag, trig, e);
  endtask

  task automatic clear_strobes();
    fcs_valid = 0; sig_valid = 0; long_pre = 0; short_pre = 0;
    tx_start = 0; tx_done = 0;
  endtask

  task automatic rand_inputs();
    fcs_valid = ($urandom_range(3) == 0); fcs_ok = $urandom_range(1);
    sig_valid = ($urandom_range(3) == 0); sig_ok = $urandom_range(1);
    sig_ht = $urandom_range(1);
    long_pre = ($urandom_range(4) == 0); short_pre = ($urandom_range(4) == 0);
    tx_start = ($urandom_range(3) == 0); tx_done = ($urandom_range(3) == 0);
    tx_need_ack = $urandom_range(1);
    if ($urandom_range(5) == 0) agc_lock = ~agc_lock;
    if ($urandom_range(4) == 0) tx_bb_on = ~tx_bb_on;
    if ($urandom_range(4) == 0) tx_rf_on = ~tx_rf_on;
    rssi = 11'(int'(level_thresh) + $urandom_range(6) - 3);
    agc_gain = 7'(int'(gain_thresh) + $urandom_range(4) - 2);
    if ($urandom_range(1) == 1) begin
      alt_i = 16'($urandom); alt_q = 16'($urandom);
    end else begin
      alt_i = 16'($urandom_range(1600) - 800);
      alt_q = 16'($urandom_range(1600) - 800);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // R11: output stays low through reset
    repeat (3) begin
      @(negedge clk);
      report("R11", trig, 1'b0);
    end

    // R10: levels already high at reset release give no edge on first sample
    agc_lock = 1; tx_bb_on = 1; rssi = 11'd500; level_thresh = 11'd100;
    cond_sel = 5'd13;
    rst = 0;
    tag_over = "R10";
    tick();
    cond_sel = 5'd18; tick();
    cond_sel = 5'd10; tick();
    // R10: strobe gives a single-cycle result on the next edge only
    cond_sel = 5'd8; long_pre = 1; tick();
    long_pre = 0; tick();
    tag_over = "";

    // R4: strict crossing, single pulse while held
    cond_sel = 5'd10; level_thresh = 11'd100;
    rssi = 11'd90;  tick();
    rssi = 11'd100; tick();
    rssi = 11'd101; tick();
    rssi = 11'd130; tick();
    rssi = 11'd2047; tick();
    cond_sel = 5'd11;
    rssi = 11'd100; tick();
    rssi = 11'd99;  tick();
    rssi = 11'd0;   tick();

    // R6: gain crossing at the top of the range
    cond_sel = 5'd14; gain_thresh = 7'd126;
    agc_gain = 7'd126; tick();
    agc_gain = 7'd127; tick();
    agc_gain = 7'd127; tick();

    // R9: amplitude corners, most negative sample and equality
    cond_sel = 5'd28; tx_bb_on = 1; level_thresh = 11'd2047;
    alt_i = 16'h8000; alt_q = 16'h0000; tick();
    alt_i = 16'd1024; alt_q = 16'(-1023); tick();
    alt_q = 16'(-1024); tick();
    tx_bb_on = 0; tick();

    // R8: gated edge with and without acknowledgement flag
    cond_sel = 5'd24; tx_need_ack = 0; tx_bb_on = 1; tick();
    tx_bb_on = 0; tick();
    tx_need_ack = 1; tx_bb_on = 1; tick();

    // constrained random sweep across every selector
    for (int c = 0; c < 32; c++) begin
      cond_sel = 5'(c);
      level_thresh = 11'($urandom_range(2000, 20));
      gain_thresh = 7'($urandom_range(120, 5));
      for (int n = 0; n < 300; n++) begin
        rand_inputs();
        tick();
      end
      clear_strobes();
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule